// File: doc/BRIEF.md
# Sample-Period Count Interrupt Timer

This block counts sample periods and raises a host interrupt after a programmed number of them. A host uses it to learn when a DMA buffer has filled, because the DMA controller has no count of its own that can interrupt the processor. Software writes a 16-bit base count as two bytes. The low byte is only stored. Writing the high byte copies the full value into a hidden down-counter. On each sample tick the counter steps down while playback or capture is enabled. On the tick after it reaches zero it underflows, sets a sticky status bit and reloads from the base registers.

The status bit is set on every underflow. The external interrupt pin shows the status bit only while interrupt-enable is high. A write to the status address clears both. When the transfer-hold input is high, counting stops for as long as an interrupt is pending, so no sample periods are lost before software services it. Counting does not depend on whether data moves by programmed I/O or by DMA, and the block has no input for that mode.

Top module: `sample_count_irq`

## Requirements
- R1: After reset the status bit, the interrupt pin, both base bytes, the hidden counter and `rd_data` are all zero.
- R2: A write to address 0 stores the low base byte and leaves the counter unchanged.
- R3: A write to address 1 stores the high base byte and, at the same edge, loads the counter with {written byte, stored low byte}.
- R4: The counter moves only on a clock with `smp_tick` high while `play_en` or `cap_en` is high. With both enables low, ticks are ignored.
- R5: After the counter is loaded with N, the status bit sets at the edge of the (N+1)th counting tick. At that edge the counter reloads from the base registers, so the next interrupt comes after another base+1 ticks.
- R6: The status bit sets on underflow even when `irq_en` is low, and the pin then stays low.
- R7: The pin is registered and equals the status bit ANDed with `irq_en` as sampled at the previous edge. It rises at the same edge as the status bit when enabled, rises one cycle after `irq_en` is raised while status is set, and falls one cycle after `irq_en` drops.
- R8: Any write to address 2 clears the status bit and the pin at that edge, whatever the data.
- R9: `rd_data` is registered and, one cycle after `rd_addr` is presented, returns the low base byte (address 0), the high base byte (address 1), the status bit in bit 0 (address 2), or zero (address 3).
- R10: While `xfer_hold` and the status bit are both high, ticks do not move the counter. With `xfer_hold` low, counting continues while status is set.
- R11: When a status-clear write and an underflow fall on the same edge, the status bit stays set.
- R12: When a high-byte write and a counting tick fall on the same edge, the load wins and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 low base, 1 high base, 2 status clear |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data |
| smp_tick | input | 1 | One-clock pulse per sample period |
| play_en | input | 1 | Playback enabled |
| cap_en | input | 1 | Capture enabled |
| xfer_hold | input | 1 | Stop counting while an interrupt is pending |
| irq_en | input | 1 | Interrupt pin enable |
| irq_status | output | 1 | Sticky interrupt status bit |
| irq_pin | output | 1 | External interrupt pin |

## Verification
Every result in this block is due one clock after the stimulus that causes it. This applies to the status bit and pin after an underflow, a clear or an `irq_en` change, and to `rd_data` after a new `rd_addr`. The bench therefore drives each stimulus just after a rising edge and stamps its expected value with the next cycle number. The monitor compares at the following falling edge, once the sampling edge has passed. An item that is still queued after its due cycle counts as a failure, so an early, late or missing change is caught, not only a wrong value. Count sequences run tick by tick, with the status expected low on every tick before the underflow and high on the tick that causes it.

// File: rtl/scirq_pkg.sv
package scirq_pkg;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_STATUS  = 2'd2,
    SEL_SPARE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/scirq_regs.sv
module scirq_regs
  import scirq_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              status_in,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  base,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr
);
  logic [BYTE_W-1:0] base_lo_q;
  logic [BYTE_W-1:0] base_hi_q;
  logic [BYTE_W-1:0] rd_mux;

  // decoded write strobes
  assign load     = wr_en && (wr_addr == SEL_BASE_HI);
  assign clr      = wr_en && (wr_addr == SEL_STATUS);
  assign load_val = {wr_data, base_lo_q};
  assign base     = {base_hi_q, base_lo_q};

  always_comb begin
    case (rd_addr)
      SEL_BASE_LO: rd_mux = base_lo_q;
      SEL_BASE_HI: rd_mux = base_hi_q;
      SEL_STATUS:  rd_mux = {{(BYTE_W-1){1'b0}}, status_in};
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      rd_data   <= '0;
    end else begin
      if (wr_en && (wr_addr == SEL_BASE_LO)) base_lo_q <= wr_data;
      if (load) base_hi_q <= wr_data;
      rd_data <= rd_mux;
    end
  end

  AST_BASE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(base)); // R9
  AST_LO_WRITE_KEEPS_HI: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_addr == SEL_BASE_LO)) |=> $stable(base_hi_q)); // R2
endmodule

// File: rtl/scirq_counter.sv
module scirq_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_tick,
  input  logic             play_en,
  input  logic             cap_en,
  input  logic             xfer_hold,
  input  logic             status,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] base,
  output logic             uf
);
  logic [CNT_W-1:0] cur_q;
  logic             run;

  // count only with a transfer direction active and no stall on a pending irq
  assign run = smp_tick && (play_en || cap_en) && (!xfer_hold || !status);
  assign uf  = run && !load && (cur_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
    end else if (load) begin
      cur_q <= load_val;
    end else if (run) begin
      if (cur_q == '0) cur_q <= base;
      else             cur_q <= cur_q - 1'b1;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(smp_tick && (play_en || cap_en)) && !load) |=> $stable(cur_q)); // R4
  AST_PENDING_STALL: assert property (@(posedge clk) disable iff (rst)
    (smp_tick && xfer_hold && status && !load) |=> $stable(cur_q)); // R10
  AST_RELOAD_BASE: assert property (@(posedge clk) disable iff (rst)
    uf |=> (cur_q == $past(base))); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> (cur_q == $past(load_val))); // R12
endmodule

// File: rtl/scirq_irq.sv
module scirq_irq (
  input  logic clk,
  input  logic rst,
  input  logic uf,
  input  logic clr,
  input  logic irq_en,
  output logic status_q,
  output logic pin_q
);
  logic status_nxt;

  // underflow has priority over a clear in the same cycle
  always_comb begin
    if (uf)       status_nxt = 1'b1;
    else if (clr) status_nxt = 1'b0;
    else          status_nxt = status_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      pin_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      pin_q    <= status_nxt && irq_en;
    end
  end

  AST_UF_SETS: assert property (@(posedge clk) disable iff (rst)
    uf |=> status_q); // R6
  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (clr && !uf) |=> (!status_q && !pin_q)); // R8
  AST_COLLIDE: assert property (@(posedge clk) disable iff (rst)
    (clr && uf) |=> status_q); // R11
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr) |=> status_q); // R6
  AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    pin_q == (status_q && $past(irq_en))); // R7
endmodule

// File: rtl/sample_count_irq.sv
module sample_count_irq
  import scirq_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              smp_tick,
  input  logic              play_en,
  input  logic              cap_en,
  input  logic              xfer_hold,
  input  logic              irq_en,
  output logic              irq_status,
  output logic              irq_pin
);
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] load_val;
  logic             load;
  logic             clr;
  logic             uf;

  scirq_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .status_in (irq_status),
    .rd_data   (rd_data),
    .base      (base),
    .load      (load),
    .load_val  (load_val),
    .clr       (clr)
  );

  scirq_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst       (rst),
    .smp_tick  (smp_tick),
    .play_en   (play_en),
    .cap_en    (cap_en),
    .xfer_hold (xfer_hold),
    .status    (irq_status),
    .load      (load),
    .load_val  (load_val),
    .base      (base),
    .uf        (uf)
  );

  scirq_irq u_irq (
    .clk      (clk),
    .rst      (rst),
    .uf       (uf),
    .clr      (clr),
    .irq_en   (irq_en),
    .status_q (irq_status),
    .pin_q    (irq_pin)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_status && !irq_pin && (rd_data == '0))); // R1
endmodule

// File: tb/test_sample_count_irq.sv
module test_sample_count_irq;
  localparam int SEL_ST  = 0;
  localparam int SEL_PIN = 1;
  localparam int SEL_RD  = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       smp_tick = 1'b0;
  logic       play_en = 1'b1;
  logic       cap_en = 1'b0;
  logic       xfer_hold = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_status;
  logic       irq_pin;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    due;
    int    sel;
    int    val;
    string req;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sample_count_irq i_sample_count_irq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .smp_tick(smp_tick), .play_en(play_en),
    .cap_en(cap_en), .xfer_hold(xfer_hold), .irq_en(irq_en),
    .irq_status(irq_status), .irq_pin(irq_pin)
  );

  // monitor: pops expectations as they come due
  always @(negedge clk) begin : mon
    item_t it;
    int    got;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      case (it.sel)
        SEL_ST:  got = int'(irq_status);
        SEL_PIN: got = int'(irq_pin);
        default: got = int'(rd_data);
      endcase
      checks++;
      if (it.due != cyc || got != it.val) begin
        errors++;
        $display("FAIL %s: sel %0d cycle %0d actual %0d expected %0d (due %0d)",
                 it.req, it.sel, cyc, got, it.val, it.due);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_next(int sel, int val, string req);
    q.push_back('{cyc + 1, sel, val, req});
  endtask

  task automatic reg_wr(int a, int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic tick_exp(int st, string req);
    expect_next(SEL_ST, st, req);
    smp_tick = 1'b1;
    step();
    smp_tick = 1'b0;
  endtask

  task automatic clear_st(string req);
    expect_next(SEL_ST, 0, req);
    expect_next(SEL_PIN, 0, req);
    reg_wr(2, 8'h5A);
  endtask

  task automatic rd_exp(int a, int val, string req);
    rd_addr = 2'(a);
    expect_next(SEL_RD, val, req);
    step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    expect_next(SEL_ST, 0, "R1");
    expect_next(SEL_PIN, 0, "R1");
    rd_exp(0, 0, "R1");
    rd_exp(1, 0, "R1");

    // R2 low write only stores: counter still 0, first tick underflows
    reg_wr(0, 5);
    rd_exp(0, 5, "R9");
    rd_exp(1, 0, "R2");
    expect_next(SEL_PIN, 0, "R6");
    tick_exp(1, "R2");
    // R7 pin rises one cycle after irq_en while status set
    irq_en = 1'b1;
    expect_next(SEL_PIN, 1, "R7");
    step();
    clear_st("R8");

    // R5 reload value 5: five ticks quiet, sixth underflows
    for (int i = 0; i < 5; i++) tick_exp(0, "R5");
    expect_next(SEL_PIN, 1, "R7");
    tick_exp(1, "R5");
    clear_st("R8");

    // R3 high write loads {hi,lo} = 2
    reg_wr(0, 2);
    reg_wr(1, 0);
    tick_exp(0, "R3");
    tick_exp(0, "R3");
    tick_exp(1, "R3");
    clear_st("R8");

    // R4 ticks ignored with both enables low; capture alone counts
    play_en = 1'b0;
    for (int i = 0; i < 4; i++) tick_exp(0, "R4");
    cap_en = 1'b1;
    tick_exp(0, "R4");
    tick_exp(0, "R4");
    tick_exp(1, "R4");
    cap_en = 1'b0;
    play_en = 1'b1;
    // R7 pin falls one cycle after irq_en drops; R6 status stays
    irq_en = 1'b0;
    expect_next(SEL_PIN, 0, "R7");
    expect_next(SEL_ST, 1, "R6");
    step();
    irq_en = 1'b1;
    clear_st("R8");

    // R10 stall while pending with hold set (count reloads to 2)
    xfer_hold = 1'b1;
    tick_exp(0, "R10");
    tick_exp(0, "R10");
    tick_exp(1, "R10");
    tick_exp(1, "R10");
    tick_exp(1, "R10");
    clear_st("R10");
    tick_exp(0, "R10");
    tick_exp(0, "R10");
    tick_exp(1, "R10");
    // hold low: counting continues while pending
    xfer_hold = 1'b0;
    tick_exp(1, "R10");
    tick_exp(1, "R10");
    clear_st("R10");
    tick_exp(1, "R10");

    // R11 clear and underflow on the same edge
    tick_exp(1, "R11");
    tick_exp(1, "R11");
    expect_next(SEL_ST, 1, "R11");
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'hFF; smp_tick = 1'b1;
    step();
    wr_en = 1'b0; smp_tick = 1'b0;
    clear_st("R8");

    // R12 load beats tick with counter at zero
    tick_exp(0, "R12");
    tick_exp(0, "R12");
    reg_wr(0, 1);
    expect_next(SEL_ST, 0, "R12");
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h00; smp_tick = 1'b1;
    step();
    wr_en = 1'b0; smp_tick = 1'b0;
    tick_exp(0, "R12");
    tick_exp(1, "R12");

    // R9 readback of all addresses
    reg_wr(0, 8'h3C);
    reg_wr(1, 8'hA5);
    rd_exp(0, 8'h3C, "R9");
    rd_exp(1, 8'hA5, "R9");
    rd_exp(2, 1, "R9");
    rd_exp(3, 0, "R9");
    clear_st("R8");
    rd_exp(2, 0, "R9");

    repeat (3) step();
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule